// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Target

This block is a synchronous target on a 4-bit multiplexed bus that carries firmware-memory traffic. An active-low frame strobe marks the start of each transaction. Each bus field is one nibble. The target first takes a start nibble, which gives the direction, while the strobe is low. It then takes an ID nibble, which it compares against a 4-bit strap, followed by seven address nibbles and a size nibble. Each transaction moves exactly one byte.

On a read, the target waits through the host's turnaround clock and then takes over the bus. It drives a turnaround nibble, a ready sync code and the data byte, and then drives one closing turnaround nibble before it floats the bus. On a write, it accepts the two data nibbles, waits through the host's turnaround clock, and then drives turnaround, sync and a closing turnaround.

Every transfer that completes reaches an internal byte port as a single-clock request. The request carries a partly decoded address. A low frame strobe at any point floats the outputs at once and restarts the sequence. Sequences that are invalid get no response of any kind.

Top module: `nbt_target`

## Requirements
- R1: While rst_ni is low, bus_oe_o and mem_req_o are 0. After reset is released, the target stays idle with the bus released until a frame begins.
- R2: In any clock where frame_ni is low, bus_oe_o is 0 and mem_req_o is 0. That clock counts as a start clock, and any transaction in progress is abandoned. A later valid frame is served normally.
- R3: The start field is the nibble on bus_i in the last clock that frame_ni is low. The frame strobe may stay low for several clocks. 4'hD starts a read and 4'hE starts a write. Any other value is ignored: there is no request and no drive.
- R4: The nibble in the first clock with frame_ni high is the ID. If it differs from strap_i, the target neither drives nor requests for the rest of that frame.
- R5: The seven nibbles after the ID form a 28-bit address, most-significant nibble first. mem_addr_o carries its low ADDR_W bits. ADDR_W is 20 for DENSITY_MBIT=8 and 19 for DENSITY_MBIT=4, so at 4 Mbit bit 19 is also dropped.
- R6: The nibble after the address is the size field. Only 4'h0 (one byte) is accepted. Any other size ends the frame with no request and no drive.
- R7: Read timing. Number the start clock as clock 0, which makes the size field clock 9. Clock 10 is the host's turnaround: the bus stays released and mem_req_o=1 with mem_we_o=0. mem_rdata_i is sampled at the end of clock 11. The target drives 4'hF in clock 11, the sync code 4'h0 in clock 12, the data bits [3:0] in clock 13, bits [7:4] in clock 14 and 4'hF in clock 15. It releases the bus in clock 16.
- R8: Write timing. Using the same numbering, data bits [3:0] arrive in clock 10 and bits [7:4] in clock 11. In clock 12 the bus is released, mem_req_o=1 with mem_we_o=1 and mem_wdata_o holding the byte. The target drives 4'hF in clock 13, 4'h0 in clock 14 and 4'hF in clock 15, and releases the bus in clock 16.
- R9: bus_oe_o is 1 only in the clocks that R7 and R8 list as driven. In the clock when mem_req_o is 1, the bus is released.
- R10: A completed transaction raises mem_req_o for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_ni | input | 1 | Active-low frame strobe |
| bus_i | input | 4 | Nibble currently on the bus |
| bus_o | output | 4 | Nibble the target drives |
| bus_oe_o | output | 1 | Output enable for bus_o |
| strap_i | input | 4 | ID strap |
| mem_req_o | output | 1 | Single-clock byte request |
| mem_we_o | output | 1 | 1 = write request, 0 = read request |
| mem_addr_o | output | ADDR_W | Decoded byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, valid one clock after a read request |

## Verification
Every result is tied to the clock index counted from the start clock. A read request appears 10 clocks after the start and a write request 12 clocks after it. The first driven nibble follows the request by one clock, and the bus is released 16 clocks after the start. The bench drives each nibble just after a falling edge and samples one nanosecond later. At each sample it compares the port values with a table of those indices that it builds itself, so the registered state from the previous edge and the combinational frame gating are both seen where they are due. Aborts are placed at specific indices, and the clocks after each one are checked for silence.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_SIZE, S_WLO, S_WHI,
    S_TAR0, S_TAR1, S_SYNC, S_RLO, S_RHI, S_ENDTAR
  } nbt_state_e;

  localparam logic [3:0] START_RD = 4'hD;
  localparam logic [3:0] START_WR = 4'hE;
  localparam logic [3:0] NIB_SYNC = 4'h0;
  localparam logic [3:0] NIB_TAR  = 4'hF;
  localparam logic [3:0] SIZE_ONE = 4'h0;
endpackage

// File: rtl/nbt_seq.sv
module nbt_seq
  import nbt_pkg::*;
#(
  parameter int ADDR_NIBS = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_ni,
  input  logic [3:0] bus_i,
  input  logic [3:0] strap_i,
  output nbt_state_e state_o,
  output logic       is_wr_o
);
  localparam int CNT_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

  nbt_state_e st_q, st_d;
  logic [3:0] start_q;
  logic [CNT_W-1:0] cnt_q;
  logic wr_q;
  logic start_ok;

  assign start_ok = (start_q == START_RD) || (start_q == START_WR);

  always_comb begin
    st_d = st_q;
    if (!frame_ni) begin
      st_d = S_START;
    end else begin
      unique case (st_q)
        S_IDLE:   st_d = S_IDLE;
        S_START:  st_d = (start_ok && bus_i == strap_i) ? S_ADDR : S_IDLE;
        S_ADDR:   if (cnt_q == CNT_LAST) st_d = S_SIZE;
        S_SIZE:   st_d = (bus_i != SIZE_ONE) ? S_IDLE : (wr_q ? S_WLO : S_TAR0);
        S_WLO:    st_d = S_WHI;
        S_WHI:    st_d = S_TAR0;
        S_TAR0:   st_d = S_TAR1;
        S_TAR1:   st_d = S_SYNC;
        S_SYNC:   st_d = wr_q ? S_ENDTAR : S_RLO;
        S_RLO:    st_d = S_RHI;
        S_RHI:    st_d = S_ENDTAR;
        S_ENDTAR: st_d = S_IDLE;
        default:  st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      start_q <= 4'h0;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (!frame_ni) start_q <= bus_i;
      if (frame_ni && st_q == S_START) begin
        wr_q  <= (start_q == START_WR);
        cnt_q <= '0;
      end else if (frame_ni && st_q == S_ADDR) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign state_o = st_q;
  assign is_wr_o = wr_q;
endmodule

// File: rtl/nbt_data.sv
module nbt_data
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  nbt_state_e        state_i,
  input  logic              is_wr_i,
  input  logic [3:0]        bus_i,
  input  logic [7:0]        rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic [7:0]        rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [7:0] wdata_q, rdata_q;

  // shifting keeps only the decoded low bits; upper nibbles fall off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= 8'h00;
      rdata_q <= 8'h00;
    end else if (frame_ni) begin
      unique case (state_i)
        S_ADDR:  addr_q <= {addr_q[ADDR_W-5:0], bus_i};
        S_WLO:   wdata_q[3:0] <= bus_i;
        S_WHI:   wdata_q[7:4] <= bus_i;
        S_TAR1:  if (!is_wr_i) rdata_q <= rdata_i;
        default: ;
      endcase
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/nbt_drv.sv
module nbt_drv
  import nbt_pkg::*;
(
  input  logic       frame_ni,
  input  nbt_state_e state_i,
  input  logic [7:0] rdata_i,
  output logic [3:0] bus_o,
  output logic       bus_oe_o
);
  logic drive;

  always_comb begin
    drive = 1'b1;
    bus_o = NIB_TAR;
    unique case (state_i)
      S_TAR1, S_ENDTAR: bus_o = NIB_TAR;
      S_SYNC:           bus_o = NIB_SYNC;
      S_RLO:            bus_o = rdata_i[3:0];
      S_RHI:            bus_o = rdata_i[7:4];
      default:          drive = 1'b0;
    endcase
  end

  // a low strobe releases the bus in the same clock
  assign bus_oe_o = drive && frame_ni;
endmodule

// File: rtl/nbt_target.sv
module nbt_target
  import nbt_pkg::*;
#(
  parameter int DENSITY_MBIT = 8,
  parameter int ADDR_NIBS    = 7,
  localparam int ADDR_W      = $clog2(DENSITY_MBIT) + 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [3:0]        bus_i,
  output logic [3:0]        bus_o,
  output logic              bus_oe_o,
  input  logic [3:0]        strap_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  nbt_state_e state;
  logic       is_wr;
  logic [7:0] rdata_q;

  nbt_seq #(.ADDR_NIBS(ADDR_NIBS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_ni(frame_ni), .bus_i(bus_i),
    .strap_i(strap_i), .state_o(state), .is_wr_o(is_wr)
  );

  nbt_data #(.ADDR_W(ADDR_W)) u_data (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_ni(frame_ni), .state_i(state),
    .is_wr_i(is_wr), .bus_i(bus_i), .rdata_i(mem_rdata_i),
    .addr_o(mem_addr_o), .wdata_o(mem_wdata_o), .rdata_o(rdata_q)
  );

  nbt_drv u_drv (
    .frame_ni(frame_ni), .state_i(state), .rdata_i(rdata_q),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o)
  );

  assign mem_req_o = frame_ni && (state == S_TAR0);
  assign mem_we_o  = is_wr;
endmodule

// File: rtl/nbt_target_chk.sv
module nbt_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_ni,
  input logic [3:0] bus_o,
  input logic       bus_oe_o,
  input logic       mem_req_o
);
  AST_FRAME_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ni |-> (!bus_oe_o && !mem_req_o)); // R2

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R10

  AST_REQ_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !bus_oe_o); // R9

  AST_FIRST_DRIVE_TAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> bus_o == 4'hF); // R7

  AST_TAKEOVER_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (!frame_ni || (bus_oe_o && bus_o == 4'hF))); // R8
endmodule

bind nbt_target nbt_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_ni(frame_ni), .bus_o(bus_o),
  .bus_oe_o(bus_oe_o), .mem_req_o(mem_req_o)
);

// File: tb/tb_nbt_target.sv
module tb_nbt_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1;
  logic [3:0] bus_in = 4'hF;
  logic [3:0] strap = 4'h5;
  logic [7:0] rdata = 8'h00;
  logic [7:0] mem_model [256];

  logic [3:0]  bus_out, bus_out4;
  logic        oe, oe4, req, req4, we, we4;
  logic [19:0] addr;
  logic [18:0] addr4;
  logic [7:0]  wdata, wdata4;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nbt_target #(.DENSITY_MBIT(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .bus_i(bus_in),
    .bus_o(bus_out), .bus_oe_o(oe), .strap_i(strap), .mem_req_o(req),
    .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  nbt_target #(.DENSITY_MBIT(4)) dut_4m (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .bus_i(bus_in),
    .bus_o(bus_out4), .bus_oe_o(oe4), .strap_i(strap), .mem_req_o(req4),
    .mem_we_o(we4), .mem_addr_o(addr4), .mem_wdata_o(wdata4), .mem_rdata_i(rdata)
  );

  // byte memory on the request port: one-clock read latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_model[i] <= 8'(i * 37 + 5);
      rdata <= 8'h00;
    end else if (req) begin
      if (we) mem_model[addr[7:0]] <= wdata;
      else    rdata <= mem_model[addr[7:0]];
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic tick(input logic f, input logic [3:0] n);
    @(negedge clk);
    frame_n = f;
    bus_in  = n;
    #1;
  endtask

  // one frame; clock 0 is the last start clock
  task automatic txn(input string tg, input logic [3:0] st, input logic [3:0] id,
                     input logic [27:0] a, input logic [3:0] sz, input logic [7:0] d,
                     input int nlead, input int abort_at);
    bit wr, resp, live, e_oe, e_req;
    int rc, db;
    logic f;
    logic [3:0] n, e_bus;
    logic [7:0] e_rd;
    wr   = (st == 4'hE);
    resp = (st == 4'hD || st == 4'hE) && id == strap && sz == 4'h0;
    rc   = wr ? 12 : 10;
    db   = wr ? 13 : 11;
    e_rd = mem_model[a[7:0]];
    for (int k = 0; k < nlead; k++) begin
      tick(1'b0, 4'h3);
      chk(tg, "oe during lead", 32'(oe), 32'd0);
    end
    for (int c = 0; c <= 16; c++) begin
      f = 1'b1;
      n = 4'hF;
      if (c == 0) begin f = 1'b0; n = st; end
      else if (c == 1) n = id;
      else if (c <= 8) n = a[4*(8-c) +: 4];
      else if (c == 9) n = sz;
      else if (wr && c == 10) n = d[3:0];
      else if (wr && c == 11) n = d[7:4];
      if (c == abort_at) begin f = 1'b0; n = 4'h0; end
      live = resp && (abort_at < 0 || c < abort_at);
      tick(f, n);
      e_oe  = live && c >= db && c <= 15;
      e_req = live && c == rc;
      chk(tg, $sformatf("oe c=%0d", c), 32'(oe), 32'(e_oe));
      chk(tg, $sformatf("oe4m c=%0d", c), 32'(oe4), 32'(e_oe));
      chk(tg, $sformatf("req c=%0d", c), 32'(req), 32'(e_req));
      if (e_oe) begin
        e_bus = 4'hF;
        if (c == db + 1) e_bus = 4'h0;
        else if (!wr && c == 13) e_bus = e_rd[3:0];
        else if (!wr && c == 14) e_bus = e_rd[7:4];
        chk(tg, $sformatf("bus c=%0d", c), 32'(bus_out), 32'(e_bus));
      end
      if (e_req) begin
        chk(tg, "we", 32'(we), 32'(wr));
        chk("R5", "addr 8M", 32'(addr), 32'(a[19:0]));
        chk("R5", "addr 4M", 32'(addr4), 32'(a[18:0]));
        if (wr) chk("R8", "wdata", 32'(wdata), 32'(d));
      end
    end
    tick(1'b1, 4'hF);
  endtask

  initial begin
    tick(1'b1, 4'hF);
    tick(1'b1, 4'hF);
    chk("R1", "oe in reset", 32'(oe), 32'd0);
    chk("R1", "req in reset", 32'(req), 32'd0);
    rst_n = 1'b1;
    tick(1'b1, 4'hF);
    chk("R1", "oe after reset", 32'(oe), 32'd0);

    // ID sweep against several straps, reads and writes alternating
    foreach (strap[b]) begin end
    for (int s = 0; s < 3; s++) begin
      strap = (s == 0) ? 4'h0 : (s == 1) ? 4'h9 : 4'hF;
      for (int id = 0; id < 16; id++)
        txn("R4", id[0] ? 4'hE : 4'hD, 4'(id), 28'h3A0_0000 | 28'(id * 273 + s * 4097),
            4'h0, 8'(id * 29 + s), 0, -1);
    end
    strap = 4'h6;

    // density decode: bit 19 and upper bits set
    txn("R5", 4'hD, 4'h6, 28'hFF8_C3A7, 4'h0, 8'h00, 0, -1);
    txn("R5", 4'hE, 4'h6, 28'h12C_3456, 4'h0, 8'hB4, 0, -1);
    txn("R7", 4'hD, 4'h6, 28'h00C_3456, 4'h0, 8'h00, 0, -1);

    // start codes
    for (int st = 0; st < 16; st++)
      txn("R3", 4'(st), 4'h6, 28'h000_1200 | 28'(st), 4'h0, 8'h5A, 0, -1);
    txn("R3", 4'hD, 4'h6, 28'h000_00E1, 4'h0, 8'h00, 3, -1);

    // size field
    for (int sz = 0; sz < 16; sz++)
      txn("R6", 4'hD, 4'h6, 28'h000_0040 | 28'(sz), 4'(sz), 8'h00, 0, -1);

    // write then read back
    for (int k = 0; k < 4; k++) begin
      txn("R8", 4'hE, 4'h6, 28'h000_0080 | 28'(k), 4'h0, 8'(8'hC3 ^ (k * 17)), 0, -1);
      txn("R7", 4'hD, 4'h6, 28'h000_0080 | 28'(k), 4'h0, 8'h00, 0, -1);
      chk("R8", "readback", 32'(mem_model[8'h80 + 8'(k)]), 32'(8'hC3 ^ (k * 17)));
    end

    // aborts
    for (int ab = 1; ab <= 15; ab += 2) begin
      txn("R2", 4'hD, 4'h6, 28'h000_0011, 4'h0, 8'h00, 0, ab);
      txn("R2", 4'hE, 4'h6, 28'h000_0022, 4'h0, 8'h77, 0, ab + 1);
      txn("R2", 4'hD, 4'h6, 28'h000_0033, 4'h0, 8'h00, 0, -1);
    end
    txn("R10", 4'hD, 4'h6, 28'h000_0010, 4'h0, 8'h00, 0, 10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule